// File: doc/BRIEF.md
# DMA Channel Trigger and Completion Controller

This block sits in front of a DMA transfer engine and decides which channel the engine works on next. Requests for a channel come from three places: a peripheral event line hard-wired to that channel (gated by a per-channel enable), a CPU register write that forces the request, and a chain request made by the completion of an earlier transfer. All three are merged into one pending bit per channel. A small dispatcher takes the lowest-numbered pending channel, clears its pending bit, and presents the channel number to the engine until the engine accepts it.

When the engine reports that the final request of a transfer is done, it hands back that channel's 32-bit options word. The block takes the 6-bit completion code from bits 17:12. If bit 20 is set, the block raises the interrupt-pending bit selected by the code. If bit 22 is set, the block re-triggers the channel selected by the code, so channels can sequence themselves without the CPU. The interrupt output is the masked OR of the interrupt-pending bits. A per-channel missed-trigger bit records any request that arrives for a channel that is already pending.

The dispatcher has two states. `ST_IDLE` waits for work, and the *grab* transition (any pending bit set) moves it to `ST_OFFER` while it latches and clears the lowest pending channel. `ST_OFFER` drives the channel to the engine, and the *handoff* transition (engine ready) returns it to `ST_IDLE`. `NUM_CH` may be 1 to 64.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset every register reads zero, `disp_valid` is low and `irq` is low.
- R2: A high `periph_evt[i]` in a cycle sets pending bit i only if bit i of the event-enable register (address 0, read/write) is 1; otherwise the event is dropped.
- R3: A write to address 1 sets the pending bit of every channel whose data bit is 1. Address 1 reads as zero.
- R4: In `ST_IDLE` with any pending bit set, the next edge enters `ST_OFFER` with `disp_ch` equal to the lowest-numbered pending channel, and clears that pending bit. `disp_valid` and `disp_ch` hold until a cycle with `disp_ready` high, after which the block is in `ST_IDLE` for at least one cycle.
- R5: A cycle with `cmpl_valid` and `cmpl_last` high, `cmpl_opt[20]` set and a code c = `cmpl_opt[17:12]` below `NUM_CH` sets interrupt-pending bit c (readable at address 3).
- R6: The same completion with `cmpl_opt[22]` set sets pending bit c, so channel c is later dispatched like any other request.
- R7: A completion with `cmpl_last` low, or with a code at or above `NUM_CH`, changes no register.
- R8: `irq` is the OR of the interrupt-pending bits ANDed with the interrupt-enable register (address 5, read/write). Writing 1s to address 4 clears interrupt-pending bits. If a completion sets a bit in the same cycle that the CPU clears it, the bit stays set.
- R9: A request for a channel whose pending bit is already set, and which is not being grabbed on that edge, sets that channel's missed bit (address 6). Writing 1s to address 6 clears missed bits, and a new miss in the same cycle wins over the clear.
- R10: Address 2 reads the pending bits. Addresses 1, 4 and 7 read zero. Reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_evt | input | NUM_CH | Per-channel peripheral event lines, active high per cycle |
| reg_wr | input | 1 | CPU register write strobe |
| reg_addr | input | 3 | CPU register address |
| reg_wdata | input | NUM_CH | CPU write data, one bit per channel |
| reg_rdata | output | NUM_CH | CPU read data for `reg_addr`, combinational |
| disp_valid | output | 1 | A channel is offered to the transfer engine |
| disp_ch | output | CH_W | Offered channel number |
| disp_ready | input | 1 | Engine accepts the offered channel |
| cmpl_valid | input | 1 | Engine reports a request completion |
| cmpl_last | input | 1 | The reported request was the final one of the transfer |
| cmpl_opt | input | 32 | Options word of the completed channel |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of events can land on the same edge. In the first, a final completion sets an interrupt-pending bit in the same cycle that the CPU writes 1 to clear that bit. In the second, a chain completion re-triggers a channel that is already pending in the same cycle that software clears its missed bit. The bench drives both pairs in a single cycle, and it judges them by reading the interrupt-pending and missed registers and the `irq` pin on the next cycle. A behavioural model that runs alongside the design is compared on every clock. That covers the less obvious overlap as well: a trigger arriving for the very channel being grabbed, which must leave it pending without recording a miss.

// File: rtl/dmatrig_pkg.sv
package dmatrig_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } disp_state_e;

    localparam int CODE_LSB = 12;
    localparam int CODE_W   = 6;
    localparam int IEN_BIT  = 20;
    localparam int CHEN_BIT = 22;

    localparam logic [2:0] A_EVT_EN  = 3'd0;
    localparam logic [2:0] A_EVT_SET = 3'd1;
    localparam logic [2:0] A_PEND    = 3'd2;
    localparam logic [2:0] A_IPEND   = 3'd3;
    localparam logic [2:0] A_ICLR    = 3'd4;
    localparam logic [2:0] A_IEN     = 3'd5;
    localparam logic [2:0] A_MISS    = 3'd6;

endpackage

// File: rtl/dtc_lowest_pick.sv
module dtc_lowest_pick #(
    parameter int N  = 16,
    parameter int CW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] idx,
    output logic [N-1:0]  oh
);
    assign any = |req;
    assign oh  = req & (~req + N'(1));

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/dtc_cmpl_decode.sv
module dtc_cmpl_decode
    import dmatrig_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         fire,
    input  logic [31:0]  opt,
    output logic [N-1:0] int_set,
    output logic [N-1:0] chain_set
);
    logic [CODE_W-1:0] code;
    assign code = opt[CODE_LSB +: CODE_W];

    // codes at or above N match no target and are dropped
    for (genvar g = 0; g < N; g++) begin : g_tgt
        logic hit;
        assign hit          = fire && (code == CODE_W'(g));
        assign int_set[g]   = hit && opt[IEN_BIT];
        assign chain_set[g] = hit && opt[CHEN_BIT];
    end
endmodule

// File: rtl/dtc_trig_collect.sv
module dtc_trig_collect #(
    parameter int N = 16
) (
    input  logic [N-1:0] periph_evt,
    input  logic [N-1:0] evt_en,
    input  logic [N-1:0] cpu_set,
    input  logic [N-1:0] chain_set,
    output logic [N-1:0] trig
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        assign trig[g] = (periph_evt[g] & evt_en[g]) | cpu_set[g] | chain_set[g];
    end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
    import dmatrig_pkg::*;
#(
    parameter  int NUM_CH = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] periph_evt,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [NUM_CH-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_rdata,
    output logic              disp_valid,
    output logic [CH_W-1:0]   disp_ch,
    input  logic              disp_ready,
    input  logic              cmpl_valid,
    input  logic              cmpl_last,
    input  logic [31:0]       cmpl_opt,
    output logic              irq
);
    disp_state_e       state_q, state_d;
    logic [CH_W-1:0]   ch_q;
    logic [NUM_CH-1:0] pend_q, ipend_q, miss_q, en_q, ien_q;

    logic              pick_any;
    logic [CH_W-1:0]   pick_idx;
    logic [NUM_CH-1:0] pick_oh;
    logic [NUM_CH-1:0] int_set, chain_set, cpu_set, trig;
    logic [NUM_CH-1:0] take, ip_clr, miss_clr, miss_hit;
    logic              grab;

    dtc_lowest_pick #(.N(NUM_CH), .CW(CH_W)) u_pick (
        .req(pend_q), .any(pick_any), .idx(pick_idx), .oh(pick_oh)
    );

    dtc_cmpl_decode #(.N(NUM_CH)) u_dec (
        .fire(cmpl_valid && cmpl_last), .opt(cmpl_opt),
        .int_set(int_set), .chain_set(chain_set)
    );

    dtc_trig_collect #(.N(NUM_CH)) u_trig (
        .periph_evt(periph_evt), .evt_en(en_q), .cpu_set(cpu_set),
        .chain_set(chain_set), .trig(trig)
    );

    assign cpu_set  = (reg_wr && reg_addr == A_EVT_SET) ? reg_wdata : '0;
    assign ip_clr   = (reg_wr && reg_addr == A_ICLR)    ? reg_wdata : '0;
    assign miss_clr = (reg_wr && reg_addr == A_MISS)    ? reg_wdata : '0;

    assign grab     = (state_q == ST_IDLE) && pick_any;
    assign take     = grab ? pick_oh : '0;
    assign miss_hit = trig & pend_q & ~take;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_any)   state_d = ST_OFFER;
            ST_OFFER: if (disp_ready) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            if (grab) ch_q <= pick_idx;
        end
    end

    // channel bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            ipend_q <= '0;
            miss_q  <= '0;
            en_q    <= '0;
            ien_q   <= '0;
        end else begin
            pend_q  <= (pend_q & ~take) | trig;
            ipend_q <= (ipend_q & ~ip_clr) | int_set;
            miss_q  <= (miss_q & ~miss_clr) | miss_hit;
            if (reg_wr && reg_addr == A_EVT_EN) en_q  <= reg_wdata;
            if (reg_wr && reg_addr == A_IEN)    ien_q <= reg_wdata;
        end
    end

    // outputs
    always_comb begin
        disp_valid = (state_q == ST_OFFER);
        disp_ch    = ch_q;
        irq        = |(ipend_q & ien_q);
        unique case (reg_addr)
            A_EVT_EN: reg_rdata = en_q;
            A_PEND:   reg_rdata = pend_q;
            A_IPEND:  reg_rdata = ipend_q;
            A_IEN:    reg_rdata = ien_q;
            A_MISS:   reg_rdata = miss_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_trig_ctrl_chk.sv
module dma_trig_ctrl_chk #(
    parameter  int NUM_CH = 16,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [CH_W-1:0]   disp_ch,
    input logic              cmpl_valid,
    input logic              cmpl_last,
    input logic [31:0]       cmpl_opt,
    input logic [NUM_CH-1:0] pend_q,
    input logic [NUM_CH-1:0] ipend_q,
    input logic [NUM_CH-1:0] miss_q
);
    logic [NUM_CH-1:0] low_bit, ch_oh;
    logic [CH_W-1:0]   code_q;
    logic              code_ok;

    assign code_ok = 32'(cmpl_opt[17:12]) < NUM_CH;

    always_comb begin
        low_bit = pend_q & (~pend_q + NUM_CH'(1));
        ch_oh = '0;
        ch_oh[disp_ch] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= cmpl_opt[12 +: CH_W];
    end

    assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> ($past(low_bit) == ch_oh));

    assert_hold_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_ch)));

    assert_gap_after_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> !disp_valid);

    assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_last && cmpl_opt[20] && code_ok) |=> ipend_q[code_q]);

    assert_chain_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_last && cmpl_opt[22] && code_ok) |=> pend_q[code_q]);

    assert_miss_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_q & ~$past(miss_q)) != '0) |-> ($past(pend_q) != '0));
endmodule

bind dma_trig_ctrl dma_trig_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_ch(disp_ch), .cmpl_valid(cmpl_valid), .cmpl_last(cmpl_last),
    .cmpl_opt(cmpl_opt), .pend_q(pend_q), .ipend_q(ipend_q), .miss_q(miss_q)
);

// File: tb/dma_trig_ctrl_bench.sv
`timescale 1ns/1ps
module dma_trig_ctrl_bench;
    localparam int N  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  periph_evt;
    logic          reg_wr;
    logic [2:0]    reg_addr;
    logic [N-1:0]  reg_wdata;
    logic [N-1:0]  reg_rdata;
    logic          disp_valid;
    logic [CW-1:0] disp_ch;
    logic          disp_ready;
    logic          cmpl_valid;
    logic          cmpl_last;
    logic [31:0]   cmpl_opt;
    logic          irq;

    always #4 clk = ~clk;

    dma_trig_ctrl #(.NUM_CH(N)) u_dma_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .periph_evt(periph_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .disp_valid(disp_valid), .disp_ch(disp_ch), .disp_ready(disp_ready),
        .cmpl_valid(cmpl_valid), .cmpl_last(cmpl_last), .cmpl_opt(cmpl_opt), .irq(irq)
    );

    // reference model state
    logic [N-1:0] m_pend, m_ip, m_miss, m_en, m_ien;
    bit           m_offer;
    int           m_ch;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    function automatic logic [31:0] opt(input int code, input bit ie, input bit ce);
        logic [31:0] o = '0;
        o[17:12] = code[5:0];
        o[20]    = ie;
        o[22]    = ce;
        return o;
    endfunction

    function automatic logic [N-1:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_en;
            3'd2: return m_pend;
            3'd3: return m_ip;
            3'd5: return m_ien;
            3'd6: return m_miss;
            default: return '0;
        endcase
    endfunction

    task automatic model_step();
        logic [N-1:0] trig, take, iset, clr_ip, clr_ms;
        int code;
        bit nxt_offer;
        if (!rst_n) begin
            m_pend = '0; m_ip = '0; m_miss = '0; m_en = '0; m_ien = '0;
            m_offer = 0; m_ch = 0;
            return;
        end
        trig = periph_evt & m_en;
        if (reg_wr && reg_addr == 3'd1) trig |= reg_wdata;
        iset = '0;
        code = int'(cmpl_opt[17:12]);
        if (cmpl_valid && cmpl_last && code < N) begin
            if (cmpl_opt[22]) trig[code] = 1'b1;
            if (cmpl_opt[20]) iset[code] = 1'b1;
        end
        take = '0;
        nxt_offer = m_offer;
        if (!m_offer) begin
            for (int i = 0; i < N; i++) begin
                if (m_pend[i]) begin
                    take[i] = 1'b1; m_ch = i; nxt_offer = 1; break;
                end
            end
        end else if (disp_ready) begin
            nxt_offer = 0;
        end
        clr_ip = (reg_wr && reg_addr == 3'd4) ? reg_wdata : '0;
        clr_ms = (reg_wr && reg_addr == 3'd6) ? reg_wdata : '0;
        m_miss = (m_miss & ~clr_ms) | (trig & m_pend & ~take);
        m_pend = (m_pend & ~take) | trig;
        m_ip   = (m_ip & ~clr_ip) | iset;
        if (reg_wr && reg_addr == 3'd0) m_en  = reg_wdata;
        if (reg_wr && reg_addr == 3'd5) m_ien = reg_wdata;
        m_offer = nxt_offer;
    endtask

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (rst_n) begin
            check("disp_valid", 64'(disp_valid), 64'(m_offer));
            if (m_offer) check("disp_ch", 64'(disp_ch), 64'(m_ch));
            check("irq", 64'(irq), 64'(|(m_ip & m_ien)));
            check("reg_rdata", 64'(reg_rdata), 64'(exp_rd(reg_addr)));
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a;
        tick();
    endtask

    task automatic evt(input logic [N-1:0] v);
        periph_evt = v;
        tick();
        periph_evt = '0;
    endtask

    task automatic cmpl(input logic [31:0] o, input bit last);
        cmpl_valid = 1; cmpl_last = last; cmpl_opt = o;
        tick();
        cmpl_valid = 0; cmpl_last = 0; cmpl_opt = '0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL %s watchdog: actual hung expected done", cur_req);
            finish_run();
        end
    end

    initial begin
        rst_n = 0; periph_evt = '0; reg_wr = 0; reg_addr = 3'd2; reg_wdata = '0;
        disp_ready = 0; cmpl_valid = 0; cmpl_last = 0; cmpl_opt = '0;
        m_pend = '0; m_ip = '0; m_miss = '0; m_en = '0; m_ien = '0; m_offer = 0; m_ch = 0;
        repeat (3) tick();
        @(negedge clk);
        rst_n = 1;

        // R1: every address reads zero after reset
        cur_req = "R1";
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R2: event gated by enable; first grab leaves the dispatcher stuck in offer
        cur_req = "R2";
        evt(16'h0008);
        rd(3'd2);
        wr(3'd0, 16'h0009);
        evt(16'h0008);
        evt(16'h0001);
        rd(3'd2);

        // R3: CPU set register
        cur_req = "R3";
        wr(3'd1, 16'h8030);
        rd(3'd2);
        rd(3'd1);

        // R9: repeated requests record misses; clear; set beats clear
        cur_req = "R9";
        wr(3'd1, 16'h0010);
        evt(16'h0001);
        rd(3'd6);
        wr(3'd6, 16'h0001);
        rd(3'd6);
        cmpl_valid = 1; cmpl_last = 1; cmpl_opt = opt(4, 0, 1);
        wr(3'd6, 16'h0010);
        cmpl_valid = 0; cmpl_last = 0; cmpl_opt = '0;
        rd(3'd6);

        // R4: drain pending channels in ascending order
        cur_req = "R4";
        reg_addr = 3'd2;
        disp_ready = 1;
        repeat (12) tick();
        disp_ready = 0;
        tick();

        // R5: completion raises interrupt pending
        cur_req = "R5";
        wr(3'd5, 16'hFFFF);
        cmpl(opt(7, 1, 0), 1);
        rd(3'd3);

        // R6: completion chains to another channel
        cur_req = "R6";
        cmpl(opt(9, 0, 1), 1);
        rd(3'd2);
        disp_ready = 1;
        repeat (4) tick();
        disp_ready = 0;
        cmpl(opt(2, 1, 1), 1);
        rd(3'd2);

        // R7: non-final and out-of-range completions are ignored
        cur_req = "R7";
        cmpl(opt(5, 1, 1), 0);
        rd(3'd3);
        cmpl(opt(40, 1, 1), 1);
        rd(3'd2);
        rd(3'd3);

        // R8: clear, masking, and set-beats-clear
        cur_req = "R8";
        wr(3'd4, 16'h0080);
        rd(3'd3);
        wr(3'd5, 16'h0004);
        cmpl_valid = 1; cmpl_last = 1; cmpl_opt = opt(2, 1, 0);
        wr(3'd4, 16'h0004);
        cmpl_valid = 0; cmpl_last = 0; cmpl_opt = '0;
        rd(3'd3);
        wr(3'd5, 16'h0000);
        rd(3'd3);

        // R10: write-only and unused addresses read zero
        cur_req = "R10";
        rd(3'd1);
        rd(3'd4);
        rd(3'd7);

        // mixed random traffic, dispatch ordering judged every cycle
        cur_req = "R4";
        for (int k = 0; k < 3000; k++) begin
            periph_evt = N'($urandom) & N'($urandom);
            reg_wr     = ($urandom % 4) == 0;
            reg_addr   = 3'($urandom);
            reg_wdata  = N'($urandom);
            disp_ready = ($urandom % 3) != 0;
            cmpl_valid = ($urandom % 2) == 0;
            cmpl_last  = ($urandom % 3) != 0;
            cmpl_opt   = opt(int'($urandom % 20), 1'($urandom), 1'($urandom));
            tick();
        end
        periph_evt = '0; reg_wr = 0; cmpl_valid = 0; disp_ready = 0;
        tick();

        done = 1;
        finish_run();
    end
endmodule